// File: doc/BRIEF.md
# Selectable Three-Mode Phase Comparator

This block is the phase detector of a digital phase-locked loop. It takes a reference signal and a feedback signal (from the oscillator directly or through a divider) and compares them. Both inputs are asynchronous to the block. Each one is brought into a fast system clock domain by a flop synchronizer and then passed to a rising-edge detector. A 2-bit mode input chooses one of three detectors that share this input pair. The first is an exclusive-OR detector, whose output duty follows the phase difference. The second is a rising-edge phase-frequency detector with three output states. The third is a rising-edge set/reset sequential detector.

The detector output is given as a pair. `drive_en` says whether the output is driven. `drive_val` is the level driven when it is. This is how the phase-frequency detector's undriven middle state is modelled. In phase-frequency mode, single-cycle `up_pulse` and `dn_pulse` outputs mark each step of the detector state, for a downstream digital loop filter. A mode change or a synchronous reset returns every detector to its idle, low state.

Top module: `phase_cmp3`

## Requirements
- R1: An input change captured at clock edge n reaches the registered outputs at edge n+2: two synchronizer flops, then one output register.
- R2: Modes 2'b00 and 2'b11 select the exclusive-OR detector: drive_en is 1 and drive_val equals the XOR of the synchronized reference and feedback levels.
- R3: Mode 2'b01 selects the phase-frequency detector. Its state takes one of down, idle and up. A reference rising edge steps it up and a feedback rising edge steps it down. It saturates at up and at down.
- R4: In phase-frequency mode, rising edges of both inputs detected in the same cycle return the state to idle, whatever the state was before.
- R5: In phase-frequency mode, the up state drives drive_en=1 with drive_val=1. The down state drives drive_en=1 with drive_val=0. The idle state gives drive_en=0 and drive_val=0.
- R6: up_pulse is high for exactly one cycle on each upward state step, and dn_pulse for one cycle on each downward step. The two are never high together, and both stay low outside mode 2'b01.
- R7: Mode 2'b10 selects the set/reset detector with drive_en=1. A reference rising edge alone sets drive_val to 1. A feedback rising edge alone clears it to 0. Rising edges of both in the same cycle leave it unchanged.
- R8: In modes 2'b01 and 2'b10, only rising-edge timing matters. Changing the high time of either input while keeping its rising edges does not change any output.
- R9: In the cycle after the mode input changes, all detector state is cleared to idle/low and no pulse is issued. Edges detected in that cycle are dropped.
- R10: The synchronous active-high reset clears the synchronizers and all detector state and selects the exclusive-OR detector. The outputs are then drive_en=1, drive_val=0 and both pulses 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Detector select: 00/11 XOR, 01 phase-frequency, 10 set/reset |
| ref_in | input | 1 | Asynchronous reference signal |
| fb_in | input | 1 | Asynchronous feedback signal |
| drive_en | output | 1 | Detector output is driven |
| drive_val | output | 1 | Level of the detector output when driven |
| up_pulse | output | 1 | One-cycle pulse on an upward phase-frequency step |
| dn_pulse | output | 1 | One-cycle pulse on a downward phase-frequency step |

## Verification
All detector state is visible at the ports every cycle. In phase-frequency mode, drive_en and drive_val together encode down, idle or up. In set/reset mode, drive_val is the state bit. A wrong state, a missed edge or a bad saturation therefore shows on drive_en or drive_val in the cycle after the edge that should have caused it. A misplaced step also shows as a wrong or missing pulse in that same cycle. A bad synchronizer depth shows as every edge-driven change arriving one cycle early or late. The bench's per-cycle model catches this on the first edge after reset.

// File: rtl/phase_cmp3.sv
module phase_cmp3 #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       ref_in,
  input  logic       fb_in,
  output logic       drive_en,
  output logic       drive_val,
  output logic       up_pulse,
  output logic       dn_pulse
);
  localparam logic [1:0] M_XOR = 2'b00;
  localparam logic [1:0] M_PFD = 2'b01;
  localparam logic [1:0] M_SR  = 2'b10;
  localparam int         SH_W  = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [SH_W-1:0] ref_sh, fb_sh;
  logic            ref_d, fb_d;
  logic [1:0]      mode_q;
  logic            x_q, sr_q, up_q, dn_q;

  wire ref_s  = ref_sh[SH_W-1];
  wire fb_s   = fb_sh[SH_W-1];
  wire rise_r = ref_s & ~ref_d;
  wire rise_f = fb_s & ~fb_d;
  wire chg    = (mode != mode_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_sh <= '0;
      fb_sh  <= '0;
      ref_d  <= 1'b0;
      fb_d   <= 1'b0;
    end else begin
      ref_sh <= {ref_sh[SH_W-2:0], ref_in};
      fb_sh  <= {fb_sh[SH_W-2:0], fb_in};
      ref_d  <= ref_s;
      fb_d   <= fb_s;
    end
  end

  wire up_set = up_q | rise_r;
  wire dn_set = dn_q | rise_f;
  wire both   = up_set & dn_set;
  wire up_n   = up_set & ~both;
  wire dn_n   = dn_set & ~both;
  wire up_mv  = (dn_q & ~dn_n) | (~up_q & up_n);
  wire dn_mv  = (up_q & ~up_n) | (~dn_q & dn_n);

  logic sr_n;
  always_comb begin
    sr_n = sr_q;
    if (rise_r && !rise_f)      sr_n = 1'b1;
    else if (rise_f && !rise_r) sr_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || chg) begin
      mode_q   <= rst ? M_XOR : mode;
      x_q      <= 1'b0;
      sr_q     <= 1'b0;
      up_q     <= 1'b0;
      dn_q     <= 1'b0;
      up_pulse <= 1'b0;
      dn_pulse <= 1'b0;
    end else begin
      up_pulse <= 1'b0;
      dn_pulse <= 1'b0;
      case (mode_q)
        M_PFD: begin
          up_q     <= up_n;
          dn_q     <= dn_n;
          up_pulse <= up_mv;
          dn_pulse <= dn_mv;
        end
        M_SR:    sr_q <= sr_n;
        default: x_q  <= ref_s ^ fb_s;
      endcase
    end
  end

  assign drive_en  = (mode_q != M_PFD) | up_q | dn_q;
  assign drive_val = (mode_q == M_PFD) ? up_q :
                     (mode_q == M_SR)  ? sr_q : x_q;
endmodule

// File: rtl/phase_cmp3_chk.sv
module phase_cmp3_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic       drive_en,
  input logic       drive_val,
  input logic       up_pulse,
  input logic       dn_pulse
);
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) !drive_en |-> !drive_val); // R5
  AST_IDLE_ONLY_PFD: assert property (@(posedge clk) disable iff (rst) !drive_en |-> $past(mode) == 2'b01); // R5
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst) !(up_pulse && dn_pulse)); // R6
  AST_UP_DIR: assert property (@(posedge clk) disable iff (rst) up_pulse |-> (!drive_en || drive_val)); // R6
  AST_DN_DIR: assert property (@(posedge clk) disable iff (rst) dn_pulse |-> (!drive_en || !drive_val)); // R6
  AST_PULSE_MODE: assert property (@(posedge clk) disable iff (rst) (up_pulse || dn_pulse) |-> $past(mode) == 2'b01); // R6
  AST_NONPFD_DRIVEN: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(mode) != 2'b01) |-> drive_en); // R7
  AST_MODECHG_QUIET: assert property (@(posedge clk) disable iff (rst) ($past(mode) != $past(mode, 2)) |-> (!up_pulse && !dn_pulse)); // R9
endmodule

bind phase_cmp3 phase_cmp3_chk u_chk (
  .clk(clk), .rst(rst), .mode(mode), .drive_en(drive_en),
  .drive_val(drive_val), .up_pulse(up_pulse), .dn_pulse(dn_pulse)
);

// File: tb/phase_cmp3_test.sv
`timescale 1ns/1ps
module phase_cmp3_test;
  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic ref_in = 1'b0, fb_in = 1'b0;
  logic drive_en, drive_val, up_pulse, dn_pulse;

  int checks = 0, errors = 0;
  string cur_req = "R10";
  bit seen = 0;

  phase_cmp3 uut (.clk(clk), .rst(rst), .mode(mode), .ref_in(ref_in), .fb_in(fb_in),
                  .drive_en(drive_en), .drive_val(drive_val),
                  .up_pulse(up_pulse), .dn_pulse(dn_pulse));

  always #2.5 clk = ~clk;

  // behavioural reference model
  logic [2:0] hr = '0, hf = '0;
  logic [1:0] mq = 2'b00;
  int pst = 0;
  bit m_sr = 0, m_x = 0, m_up = 0, m_dn = 0;

  always @(posedge clk) begin
    seen <= 1'b1;
    if (rst) begin
      hr = '0; hf = '0; mq = 2'b00; pst = 0;
      m_sr = 0; m_x = 0; m_up = 0; m_dn = 0;
    end else begin
      bit rr, rf;
      int nxt;
      rr = hr[1] && !hr[2];
      rf = hf[1] && !hf[2];
      m_up = 0; m_dn = 0;
      if (mode != mq) begin
        mq = mode; pst = 0; m_sr = 0; m_x = 0;
      end else if (mq == 2'b01) begin
        if (rr && rf) nxt = 0;
        else begin
          nxt = pst + int'(rr) - int'(rf);
          if (nxt > 1) nxt = 1;
          if (nxt < -1) nxt = -1;
        end
        m_up = nxt > pst;
        m_dn = nxt < pst;
        pst = nxt;
      end else if (mq == 2'b10) begin
        if (rr && !rf) m_sr = 1;
        else if (rf && !rr) m_sr = 0;
      end else begin
        m_x = hr[1] ^ hf[1];
      end
      hr = {hr[1:0], ref_in};
      hf = {hf[1:0], fb_in};
    end
  end

  task automatic chk(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0b exp=%0b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (seen) begin
      logic e_en, e_val;
      if (mq == 2'b01) begin e_en = (pst != 0); e_val = (pst == 1); end
      else if (mq == 2'b10) begin e_en = 1; e_val = m_sr; end
      else begin e_en = 1; e_val = m_x; end
      chk("drive_en", drive_en, e_en);
      chk("drive_val", drive_val, e_val);
      chk("up_pulse", up_pulse, m_up);
      chk("dn_pulse", dn_pulse, m_dn);
    end
  end

  task automatic run(input int n, input int pr, input int dr, input int phr,
                     input int pf, input int df, input int phf);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ref_in = (pr == 0) ? 1'b0 : (((i + phr) % pr) < dr);
      fb_in  = (pf == 0) ? 1'b0 : (((i + phf) % pf) < df);
    end
  endtask

  initial begin
    cur_req = "R10";
    repeat (4) @(negedge clk);
    rst = 0;
    cur_req = "R1";   run(12, 0, 0, 0, 0, 0, 0); run(12, 100, 50, 0, 0, 0, 0);
    cur_req = "R2";   run(200, 20, 10, 0, 20, 10, 5);
    mode = 2'b11;     run(100, 14, 7, 0, 10, 3, 2);
    cur_req = "R3";   mode = 2'b01; run(200, 16, 8, 0, 20, 10, 3);
    cur_req = "R3";   run(200, 24, 12, 0, 16, 8, 0);
    cur_req = "R5";   run(200, 20, 10, 0, 20, 10, 4);
    cur_req = "R4";   run(120, 10, 5, 0, 10, 5, 0);
    cur_req = "R4";   run(200, 6, 3, 0, 9, 4, 0);
    cur_req = "R6";   run(200, 12, 6, 0, 30, 15, 7);
    cur_req = "R8";   run(200, 20, 2, 0, 20, 17, 6);
    cur_req = "R7";   mode = 2'b10; run(200, 16, 8, 0, 20, 10, 3);
    cur_req = "R7";   run(80, 8, 4, 0, 8, 4, 0);
    cur_req = "R8";   run(200, 20, 3, 0, 20, 15, 7);
    cur_req = "R9";
    for (int k = 0; k < 30; k++) begin
      mode = 2'(k % 3);
      run(7 + (k % 4), 5, 2, k, 7, 3, 1);
    end
    cur_req = "R10";  mode = 2'b01; run(40, 9, 4, 0, 0, 0, 0);
    rst = 1;          run(3, 9, 4, 0, 0, 0, 0);
    rst = 0;          run(60, 9, 4, 0, 13, 6, 2);
    run(10, 0, 0, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule